// File: doc/BRIEF.md
# Multi-page-size TLB lookup

This block is a fully associative address translation cache. Each slot holds a match descriptor (virtual tag, page size, sticky flag, valid) and a target descriptor (physical page base and a small attribute field). A lookup presents a 32-bit virtual address. Every valid slot compares the address with its own tag under the mask of its own page size, so 16 MB, 1 MB, 64 KB and 4 KB pages can share the same array. One cycle later the block reports exactly one of three outcomes: a single hit with its translated physical address, a miss, or a multi-hit fault.

Slots are written by index through a load port, which checks that the virtual tag is aligned to the chosen page size. Any slot can be read back at any time as a pair of 32-bit words. Slots can be invalidated in two ways. A global flush drops every slot that is not marked sticky. An address flush drops the slots whose masked tag covers a given address.

Top module: `tlb_cam`

## Requirements
- R1: The page size code is 0 for 4 KB, 1 for 64 KB, 2 for 1 MB and 3 for 16 MB. The compare masks are 0xFFFFF000, 0xFFFF0000, 0xFFF00000 and 0xFF000000, and a slot ignores the lookup address bits that lie outside its mask.
- R2: A slot whose valid bit is clear never matches. After reset every slot is invalid and all read-back words are zero.
- R3: An accepted load always sets the valid bit of the written slot, and the slot matches from the next cycle on.
- R4: A load whose virtual address has any bit set outside the page-size mask is rejected. `ld_err` is high in the cycle after it, and the target slot keeps its previous contents.
- R5: A lookup that matches no valid slot reports `res_miss` with `res_pa` = 0.
- R6: A lookup that matches two or more valid slots reports `res_multihit`, with `res_hit` low and `res_pa` = 0.
- R7: A lookup that matches exactly one slot reports `res_hit`, and `res_pa` = (base AND mask) OR (address AND NOT mask).
- R8: The read-back CAM word is {tag[31:12], 8'b0, valid, sticky, size[1:0]}. The read-back RAM word is {base[31:12], 12'b0} OR the attribute in its low bits. Both show the slot selected by `rd_idx` as of the last clock edge.
- R9: A global flush clears the valid bit of every slot whose sticky flag is clear and leaves sticky slots valid.
- R10: An address flush clears every valid slot whose tag, under that slot's own mask, equals the flush address. Other slots are untouched.
- R11: Results are registered. `res_valid` is high in the cycle after `lookup_req`. When `res_valid` is low, all flags and `res_pa` are zero.
- R12: A load and a flush in the same cycle leave the loaded slot valid. A lookup in the same cycle as a load sees the contents from before the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lookup_req | input | 1 | Lookup strobe |
| lookup_va | input | 32 | Virtual address to translate |
| res_valid | output | 1 | Registered lookup result present |
| res_hit | output | 1 | Exactly one slot matched |
| res_miss | output | 1 | No slot matched |
| res_multihit | output | 1 | More than one slot matched |
| res_pa | output | 32 | Translated physical address |
| ld_en | input | 1 | Load strobe |
| ld_idx | input | IDX_W | Slot to write |
| ld_va | input | 32 | Virtual tag address, aligned to page size |
| ld_size | input | 2 | Page size code |
| ld_keep | input | 1 | Sticky flag, survives global flush |
| ld_pbase | input | 20 | Physical page base bits 31:12 |
| ld_attr | input | ATTR_W | Attribute bits, stored only |
| ld_err | output | 1 | Previous-cycle load rejected as misaligned |
| rd_idx | input | IDX_W | Slot to read back |
| rd_cam | output | 32 | Read-back CAM word |
| rd_ram | output | 32 | Read-back RAM word |
| flush_all | input | 1 | Global flush of non-sticky slots |
| flush_one | input | 1 | Address flush strobe |
| flush_va | input | 32 | Address to flush |

## Verification
The bench builds the block with ENTRIES = 8 and ATTR_W = 6. With only eight slots, a long random run keeps several slots valid and overlapping most of the time, across all four page sizes. That makes multi-hit outcomes, flushes that strike several slots at once and loads that overwrite live slots occur often. Eight slots also make a full read-back sweep of every slot cheap after each directed phase.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    typedef enum logic [1:0] {
        PG_4K  = 2'd0,
        PG_64K = 2'd1,
        PG_1M  = 2'd2,
        PG_16M = 2'd3
    } pg_size_e;

    localparam int VA_W    = 32;
    localparam int TAG_LSB = 12;
    localparam int TAG_W   = VA_W - TAG_LSB;

    typedef struct packed {
        logic             valid;
        logic             keep;
        pg_size_e         size;
        logic [TAG_W-1:0] tag;
    } cam_t;

    function automatic logic [VA_W-1:0] pg_mask(input pg_size_e s);
        logic [VA_W-1:0] m;
        case (s)
            PG_4K:   m = 32'hFFFF_F000;
            PG_64K:  m = 32'hFFFF_0000;
            PG_1M:   m = 32'hFFF0_0000;
            default: m = 32'hFF00_0000;
        endcase
        return m;
    endfunction

    function automatic logic [VA_W-1:0] cam_word(input cam_t c);
        return {c.tag, 8'h00, c.valid, c.keep, c.size};
    endfunction

endpackage

// File: rtl/tlb_entry.sv
module tlb_entry
    import tlb_pkg::*;
#(
    parameter int ATTR_W = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  cam_t                 wr_cam,
    input  logic [TAG_W-1:0]     wr_pbase,
    input  logic [ATTR_W-1:0]    wr_attr,
    input  logic                 flush_all,
    input  logic                 flush_one,
    input  logic [VA_W-1:0]      flush_va,
    input  logic [VA_W-1:0]      look_va,
    output logic                 hit,
    output logic [VA_W-1:0]      xlat_pa,
    output cam_t                 cam_q,
    output logic [TAG_W-1:0]     pbase_q,
    output logic [ATTR_W-1:0]    attr_q
);

    logic [VA_W-1:0] mask;
    logic [VA_W-1:0] tag_full;
    logic            flush_hit;
    logic            drop;

    always_comb begin
        mask      = pg_mask(cam_q.size);
        tag_full  = {cam_q.tag, {TAG_LSB{1'b0}}};
        hit       = cam_q.valid && (((look_va ^ tag_full) & mask) == '0);
        flush_hit = cam_q.valid && (((flush_va ^ tag_full) & mask) == '0);
        xlat_pa   = ({pbase_q, {TAG_LSB{1'b0}}} & mask) | (look_va & ~mask);
        drop      = (flush_all && !cam_q.keep) || (flush_one && flush_hit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cam_q   <= '0;
            pbase_q <= '0;
            attr_q  <= '0;
        end else if (wr_en) begin
            cam_q       <= wr_cam;
            cam_q.valid <= 1'b1;
            pbase_q     <= wr_pbase;
            attr_q      <= wr_attr;
        end else if (drop) begin
            cam_q.valid <= 1'b0;
        end
    end

endmodule

// File: rtl/tlb_resolve.sv
module tlb_resolve
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 32
) (
    input  logic [ENTRIES-1:0]           hits,
    input  logic [ENTRIES-1:0][VA_W-1:0] pas,
    output logic                         any_hit,
    output logic                         many_hit,
    output logic [VA_W-1:0]              pa_sel
);

    always_comb begin
        any_hit  = 1'b0;
        many_hit = 1'b0;
        pa_sel   = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            many_hit = many_hit | (any_hit & hits[i]);
            any_hit  = any_hit | hits[i];
            if (hits[i]) pa_sel = pa_sel | pas[i];
        end
    end

endmodule

// File: rtl/tlb_readback.sv
module tlb_readback
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 32,
    parameter int ATTR_W  = 6,
    parameter int IDX_W   = 5
) (
    input  cam_t [ENTRIES-1:0]              cams,
    input  logic [ENTRIES-1:0][TAG_W-1:0]   pbases,
    input  logic [ENTRIES-1:0][ATTR_W-1:0]  attrs,
    input  logic [IDX_W-1:0]                idx,
    output logic [VA_W-1:0]                 cam_out,
    output logic [VA_W-1:0]                 ram_out
);

    always_comb begin
        cam_out = '0;
        ram_out = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (idx == IDX_W'(i)) begin
                cam_out = cam_word(cams[i]);
                ram_out = {pbases[i], {TAG_LSB{1'b0}}} | VA_W'(attrs[i]);
            end
        end
    end

endmodule

// File: rtl/tlb_cam.sv
module tlb_cam
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 32,
    parameter int ATTR_W  = 6,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lookup_req,
    input  logic [31:0]       lookup_va,
    output logic              res_valid,
    output logic              res_hit,
    output logic              res_miss,
    output logic              res_multihit,
    output logic [31:0]       res_pa,
    input  logic              ld_en,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic [31:0]       ld_va,
    input  logic [1:0]        ld_size,
    input  logic              ld_keep,
    input  logic [19:0]       ld_pbase,
    input  logic [ATTR_W-1:0] ld_attr,
    output logic              ld_err,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [31:0]       rd_cam,
    output logic [31:0]       rd_ram,
    input  logic              flush_all,
    input  logic              flush_one,
    input  logic [31:0]       flush_va
);

    cam_t                            wr_cam;
    logic                            misaligned;
    logic                            ld_ok;
    cam_t [ENTRIES-1:0]              cam_arr;
    logic [ENTRIES-1:0][TAG_W-1:0]   pbase_arr;
    logic [ENTRIES-1:0][ATTR_W-1:0]  attr_arr;
    logic [ENTRIES-1:0][VA_W-1:0]    xlat_arr;
    logic [ENTRIES-1:0]              hit_vec;
    logic                            any_hit;
    logic                            many_hit;
    logic [VA_W-1:0]                 pa_sel;

    always_comb begin
        wr_cam.valid = 1'b1;
        wr_cam.keep  = ld_keep;
        wr_cam.size  = pg_size_e'(ld_size);
        wr_cam.tag   = ld_va[VA_W-1:TAG_LSB];
        misaligned   = |(ld_va & ~pg_mask(pg_size_e'(ld_size)));
        ld_ok        = ld_en && !misaligned;
    end

    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        tlb_entry #(.ATTR_W(ATTR_W)) u_entry (
            .clk       (clk),
            .rst       (rst),
            .wr_en     (ld_ok && (ld_idx == IDX_W'(i))),
            .wr_cam    (wr_cam),
            .wr_pbase  (ld_pbase),
            .wr_attr   (ld_attr),
            .flush_all (flush_all),
            .flush_one (flush_one),
            .flush_va  (flush_va),
            .look_va   (lookup_va),
            .hit       (hit_vec[i]),
            .xlat_pa   (xlat_arr[i]),
            .cam_q     (cam_arr[i]),
            .pbase_q   (pbase_arr[i]),
            .attr_q    (attr_arr[i])
        );
    end

    tlb_resolve #(.ENTRIES(ENTRIES)) u_resolve (
        .hits     (hit_vec),
        .pas      (xlat_arr),
        .any_hit  (any_hit),
        .many_hit (many_hit),
        .pa_sel   (pa_sel)
    );

    tlb_readback #(.ENTRIES(ENTRIES), .ATTR_W(ATTR_W), .IDX_W(IDX_W)) u_readback (
        .cams    (cam_arr),
        .pbases  (pbase_arr),
        .attrs   (attr_arr),
        .idx     (rd_idx),
        .cam_out (rd_cam),
        .ram_out (rd_ram)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid    <= 1'b0;
            res_hit      <= 1'b0;
            res_miss     <= 1'b0;
            res_multihit <= 1'b0;
            res_pa       <= '0;
            ld_err       <= 1'b0;
        end else begin
            res_valid    <= lookup_req;
            res_hit      <= lookup_req && any_hit && !many_hit;
            res_miss     <= lookup_req && !any_hit;
            res_multihit <= lookup_req && many_hit;
            res_pa       <= (lookup_req && any_hit && !many_hit) ? pa_sel : '0;
            ld_err       <= ld_en && misaligned;
        end
    end

endmodule

// File: rtl/tlb_cam_chk.sv
module tlb_cam_chk (
    input logic        clk,
    input logic        rst,
    input logic        lookup_req,
    input logic        res_valid,
    input logic        res_hit,
    input logic        res_miss,
    input logic        res_multihit,
    input logic [31:0] res_pa,
    input logic        ld_en,
    input logic        ld_err
);

    // R11
    res_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (res_valid == $past(lookup_req)));

    // R5
    one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> ($countones({res_hit, res_miss, res_multihit}) == 1));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> (!res_hit && !res_miss && !res_multihit && res_pa == 32'h0));

    // R6
    multihit_no_pa_chk: assert property (@(posedge clk) disable iff (rst)
        res_multihit |-> (res_pa == 32'h0 && !res_hit));

    // R4
    err_after_load_chk: assert property (@(posedge clk) disable iff (rst)
        (ld_err && !$past(rst)) |-> $past(ld_en));

endmodule

bind tlb_cam tlb_cam_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .lookup_req   (lookup_req),
    .res_valid    (res_valid),
    .res_hit      (res_hit),
    .res_miss     (res_miss),
    .res_multihit (res_multihit),
    .res_pa       (res_pa),
    .ld_en        (ld_en),
    .ld_err       (ld_err)
);

// File: tb/tlb_cam_test.sv
`timescale 1ns/1ps
module tlb_cam_test;

    localparam int N  = 8;
    localparam int AW = 6;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          lookup_req = 1'b0;
    logic [31:0]   lookup_va = '0;
    logic          res_valid, res_hit, res_miss, res_multihit;
    logic [31:0]   res_pa;
    logic          ld_en = 1'b0;
    logic [IW-1:0] ld_idx = '0;
    logic [31:0]   ld_va = '0;
    logic [1:0]    ld_size = '0;
    logic          ld_keep = 1'b0;
    logic [19:0]   ld_pbase = '0;
    logic [AW-1:0] ld_attr = '0;
    logic          ld_err;
    logic [IW-1:0] rd_idx = '0;
    logic [31:0]   rd_cam, rd_ram;
    logic          flush_all = 1'b0;
    logic          flush_one = 1'b0;
    logic [31:0]   flush_va = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // behavioural model state
    logic          mv [N];
    logic          mk [N];
    logic [1:0]    ms [N];
    logic [31:0]   mt [N];
    logic [19:0]   mp [N];
    logic [AW-1:0] ma [N];

    always #2.5 clk = ~clk;

    tlb_cam #(.ENTRIES(N), .ATTR_W(AW)) uut (.*);

    function automatic logic [31:0] bmask(input logic [1:0] s);
        case (s)
            2'd0:    return 32'hFFFF_F000;
            2'd1:    return 32'hFFFF_0000;
            2'd2:    return 32'hFFF0_0000;
            default: return 32'hFF00_0000;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(input string tag);
        int cnt = 0;
        logic [31:0] m;
        logic [31:0] epa = '0;
        logic [35:0] eres;
        logic eerr;
        for (int i = 0; i < N; i++) begin
            m = bmask(ms[i]);
            if (mv[i] && (((lookup_va ^ mt[i]) & m) == 0)) begin
                cnt++;
                epa = ({mp[i], 12'h0} & m) | (lookup_va & ~m);
            end
        end
        if (!lookup_req)   eres = '0;
        else if (cnt == 0) eres = {4'b1010, 32'h0};
        else if (cnt == 1) eres = {4'b1100, epa};
        else               eres = {4'b1001, 32'h0};
        eerr = ld_en && ((ld_va & ~bmask(ld_size)) != 0);
        for (int i = 0; i < N; i++) begin
            m = bmask(ms[i]);
            if (ld_en && !eerr && ld_idx == IW'(i)) begin
                mv[i] = 1'b1; mk[i] = ld_keep; ms[i] = ld_size;
                mt[i] = ld_va; mp[i] = ld_pbase; ma[i] = ld_attr;
            end else begin
                if (flush_all && !mk[i]) mv[i] = 1'b0;
                if (flush_one && mv[i] && (((flush_va ^ mt[i]) & m) == 0)) mv[i] = 1'b0;
            end
        end
        @(posedge clk);
        #1;
        chk(tag, {res_valid, res_hit, res_miss, res_multihit, res_pa}, eres);
        chk("R4", ld_err, eerr);
        chk("R8", rd_cam, {mt[rd_idx][31:12], 8'h00, mv[rd_idx], mk[rd_idx], ms[rd_idx]});
        chk("R8", rd_ram, {mp[rd_idx], 12'h0} | 32'(ma[rd_idx]));
        lookup_req = 0; ld_en = 0; flush_all = 0; flush_one = 0;
    endtask

    task automatic load(input int idx, input logic [31:0] va, input logic [1:0] sz,
                        input logic keep, input logic [19:0] pb, input logic [AW-1:0] at);
        ld_en = 1; ld_idx = IW'(idx); ld_va = va; ld_size = sz;
        ld_keep = keep; ld_pbase = pb; ld_attr = at;
    endtask

    task automatic look(input logic [31:0] va, input string tag);
        lookup_req = 1; lookup_va = va;
        cyc(tag);
    endtask

    task automatic sweep();
        for (int i = 0; i < N; i++) begin
            rd_idx = IW'(i);
            cyc("R8");
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            mv[i] = 0; mk[i] = 0; ms[i] = 0; mt[i] = 0; mp[i] = 0; ma[i] = 0;
        end
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R2: reset state, everything misses and reads zero
        look(32'h1234_5ABC, "R2");
        sweep();

        // R3 R7: 4 KB slot
        load(0, 32'h1234_5000, 2'd0, 0, 20'hABCDE, 6'h05); cyc("R3");
        look(32'h1234_5ABC, "R7");
        chk("R7", res_pa, 32'hABCD_EABC);
        chk("R3", rd_cam[3], 1'b0);  // rd_idx still 7
        rd_idx = 0; cyc("R3");
        chk("R3", rd_cam, 32'h1234_5008);

        // R1: other page sizes
        load(1, 32'h4000_0000, 2'd1, 1, 20'h55550, 6'h11); cyc("R1");
        load(2, 32'h8010_0000, 2'd2, 0, 20'h22200, 6'h22); cyc("R1");
        load(3, 32'h0300_0000, 2'd3, 0, 20'h7F000, 6'h3F); cyc("R1");
        look(32'h4000_ABCD, "R1");
        chk("R1", res_pa, 32'h5555_ABCD);
        look(32'h801F_FFFF, "R1");
        chk("R1", res_pa, 32'h222F_FFFF);
        look(32'h8020_0000, "R5");
        chk("R5", res_miss, 1'b1);
        look(32'h03AB_CDEF, "R1");
        chk("R1", res_pa, 32'h7FAB_CDEF);

        // R4: misaligned load rejected, slot stays empty
        load(4, 32'h5000_1000, 2'd1, 0, 20'h11111, 6'h01); rd_idx = 4; cyc("R4");
        chk("R4", ld_err, 1'b1);
        look(32'h5000_1000, "R4");
        chk("R4", rd_cam, 32'h0);

        // R6: overlapping slots
        load(5, 32'h1230_0000, 2'd2, 0, 20'h99900, 6'h02); cyc("R6");
        look(32'h1234_5ABC, "R6");
        chk("R6", res_multihit, 1'b1);

        // R10: address flush hits both overlapping slots
        flush_one = 1; flush_va = 32'h1234_5FFF; cyc("R10");
        look(32'h1234_5ABC, "R10");
        chk("R10", res_miss, 1'b1);
        look(32'h4000_0000, "R10");

        // R9: global flush keeps only the sticky slot
        flush_all = 1; cyc("R9");
        look(32'h4000_ABCD, "R9");
        chk("R9", res_hit, 1'b1);
        look(32'h03AB_CDEF, "R9");
        chk("R9", res_miss, 1'b1);
        sweep();

        // R12: load with flush and lookup in the same cycle
        load(6, 32'h6000_0000, 2'd0, 0, 20'h00ABC, 6'h07);
        flush_all = 1; lookup_req = 1; lookup_va = 32'h6000_0010; rd_idx = 6;
        cyc("R12");
        chk("R12", res_miss, 1'b1);
        look(32'h6000_0010, "R12");
        chk("R12", res_pa, 32'h00AB_C010);

        // R11: idle cycles
        cyc("R11");
        chk("R11", res_valid, 1'b0);

        // random mix
        for (int n = 0; n < 600; n++) begin
            logic [31:0] r, va;
            logic [1:0] sz;
            r  = $urandom;
            sz = r[1:0];
            va = {8'h12, 4'(r[3:2]), 4'(r[5:4]), 4'(r[7:6]), 12'(r[19:8])};
            rd_idx = IW'(r[30:28]);
            if (r[20]) begin
                ld_en = 1; ld_idx = IW'(r[23:21]); ld_size = sz;
                ld_va = r[24] ? va : (va & bmask(sz));
                ld_keep = r[25]; ld_pbase = 20'(r[31:12] ^ 20'h5A5A5); ld_attr = AW'(r[11:6]);
            end
            if (r[26]) begin lookup_req = 1; lookup_va = va ^ {20'h0, 12'(r[31:20])}; end
            if (r[27] && r[2]) begin flush_one = 1; flush_va = va; end
            if (r[27] && r[9] && r[10] && r[11]) flush_all = 1;
            cyc("R7");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule